// File: doc/BRIEF.md
# Interrupt Master Enable Controller

This block keeps the single global interrupt enable flag of a small 8-bit CPU core. It decides in which cycle a pending interrupt line is accepted, and it runs the fixed handler entry sequence that follows. The decoder hands it one-cycle strobes for the disable, enable, return-from-interrupt and halt instructions. The interrupt logic hands it a vector of pending lines and a per-line enable mask.

When a request is accepted, the block selects the winning line. It raises a dispatch strobe together with a one-hot acknowledge that clears that line's pending bit. It also drops the global enable flag on its own. It then asks the stack logic to store the return address, high byte first, and finally tells the fetch unit to load the handler address. There is only one flag and one fixed address scheme: no non-maskable input, no mode select and no vector base register.

While halted, the block reports that state. It leaves the halted state as soon as any enabled line is pending. If the flag is clear at that point, execution simply resumes without a dispatch.

Top module: `irq_master_ctrl`

## Requirements
- R1: After a synchronous reset, the enable flag is 0, the block is running (not halted), and dispatch, ack, push_req, push_hi, pc_load and halt_active are all 0. A pending enabled line is therefore not taken until the flag is set.
- R2: A disable strobe clears the enable flag and an enable strobe sets it, effective from the next cycle. If both come in the same cycle, the disable wins.
- R3: A return-from-interrupt strobe sets the enable flag, effective from the next cycle.
- R4: A line is accepted only at a clock edge where the flag is 1 and both its req_vec bit and its en_mask bit are 1. In the following cycle, dispatch is 1 for exactly one cycle.
- R5: Among the lines that can be taken, the lowest index wins. handler_addr is 0x0040 + 8*index (16 bits): line 0 gives 0x0040, line 4 gives 0x0060.
- R6: ack is 0 except in the dispatch cycle. In that cycle it is one-hot with bit i set for the winning line i.
- R7: Accepting a line clears the enable flag, so a second pending line is not taken after the sequence ends until the flag is set again.
- R8: The entry sequence lasts 5 cycles. Cycle 0 raises dispatch/ack. Cycle 1 raises nothing. Cycle 2 raises push_req with push_hi=1 (high byte). Cycle 3 raises push_req with push_hi=0 (low byte). Cycle 4 raises pc_load. handler_addr is stable through all five cycles.
- R9: Disable, enable and return strobes have no effect in the cycle a line is accepted or during the five sequence cycles.
- R10: A halt strobe in the running state makes halt_active 1 from the next cycle. halt_active stays 1 while no enabled line is pending.
- R11: In the halted state, an enabled pending line ends the halt in the next cycle. With the flag at 0, no dispatch follows and the line stays pending. With the flag at 1, the sequence of R8 starts instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| di_stb | input | 1 | Disable instruction decoded |
| ei_stb | input | 1 | Enable instruction decoded |
| reti_stb | input | 1 | Return-from-interrupt decoded |
| halt_stb | input | 1 | Halt instruction decoded |
| req_vec | input | 5 | Pending request lines |
| en_mask | input | 5 | Per-line enable |
| dispatch | output | 1 | First cycle of handler entry |
| ack | output | 5 | One-hot clear of the served line |
| handler_addr | output | 16 | Handler address of the served line |
| push_req | output | 1 | Return-address byte store request |
| push_hi | output | 1 | 1 = high byte, 0 = low byte |
| pc_load | output | 1 | Load handler_addr into the program counter |
| halt_active | output | 1 | Core is halted |

## Verification
On every cycle, the assertions check the shape of the entry sequence: the one-hot ack, the fixed push and load order, the stable handler address, the requirement that the served line was pending and enabled, and that halt_active stays low during entry. Only the bench scenarios can show which line wins, what the flag does after disable, enable, return and entry (including strobes dropped during entry), and the two ways out of halt. None of these can be observed from a single cycle.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

    localparam int DEF_LINES    = 5;
    localparam int DEF_ADDR_W   = 16;
    localparam int DEF_VEC_BASE = 'h40;
    localparam int DEF_VEC_STEP = 8;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_HALT = 3'd1,
        ST_ENT0 = 3'd2,
        ST_ENT1 = 3'd3,
        ST_ENT2 = 3'd4,
        ST_ENT3 = 3'd5,
        ST_ENT4 = 3'd6
    } seq_e;

    function automatic logic in_entry(input seq_e s);
        return (s == ST_ENT0) || (s == ST_ENT1) || (s == ST_ENT2) ||
               (s == ST_ENT3) || (s == ST_ENT4);
    endfunction

endpackage

// File: rtl/irqm_pick.sv
module irqm_pick #(
    parameter int LINES = irqm_pkg::DEF_LINES,
    parameter int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic [LINES-1:0] live,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = |live;
        idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (live[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irqm_flag.sv
module irqm_flag (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic busy,
    input  logic di_stb,
    input  logic ei_stb,
    input  logic reti_stb,
    output logic ime
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ime <= 1'b0;
        end else if (take) begin
            ime <= 1'b0;
        end else if (!busy) begin
            if (di_stb)                ime <= 1'b0;
            else if (ei_stb || reti_stb) ime <= 1'b1;
        end
    end
endmodule

// File: rtl/irqm_seq.sv
module irqm_seq
    import irqm_pkg::*;
#(
    parameter int LINES    = DEF_LINES,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int VEC_BASE = DEF_VEC_BASE,
    parameter int VEC_STEP = DEF_VEC_STEP,
    parameter int IDX_W    = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ime,
    input  logic              hit,
    input  logic [IDX_W-1:0]  idx,
    input  logic              halt_stb,
    output logic              take,
    output logic              busy,
    output logic              dispatch,
    output logic [LINES-1:0]  ack,
    output logic [ADDR_W-1:0] handler_addr,
    output logic              push_req,
    output logic              push_hi,
    output logic              pc_load,
    output logic              halt_active
);
    seq_e             st_q, st_d;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        take = ((st_q == ST_RUN) || (st_q == ST_HALT)) && ime && hit;
        busy = take || in_entry(st_q);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:  if (take) st_d = ST_ENT0;
                     else if (halt_stb) st_d = ST_HALT;
            ST_HALT: if (take) st_d = ST_ENT0;
                     else if (hit) st_d = ST_RUN;
            ST_ENT0: st_d = ST_ENT1;
            ST_ENT1: st_d = ST_ENT2;
            ST_ENT2: st_d = ST_ENT3;
            ST_ENT3: st_d = ST_ENT4;
            ST_ENT4: st_d = ST_RUN;
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_RUN;
            idx_q <= '0;
        end else begin
            st_q <= st_d;
            if (take) idx_q <= idx;
        end
    end

    always_comb begin
        ack = '0;
        if (st_q == ST_ENT0) ack[idx_q] = 1'b1;
        dispatch     = (st_q == ST_ENT0);
        push_req     = (st_q == ST_ENT2) || (st_q == ST_ENT3);
        push_hi      = (st_q == ST_ENT2);
        pc_load      = (st_q == ST_ENT4);
        halt_active  = (st_q == ST_HALT);
        handler_addr = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(idx_q);
    end
endmodule

// File: rtl/irq_master_ctrl.sv
module irq_master_ctrl
    import irqm_pkg::*;
#(
    parameter int LINES    = DEF_LINES,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int VEC_BASE = DEF_VEC_BASE,
    parameter int VEC_STEP = DEF_VEC_STEP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              di_stb,
    input  logic              ei_stb,
    input  logic              reti_stb,
    input  logic              halt_stb,
    input  logic [LINES-1:0]  req_vec,
    input  logic [LINES-1:0]  en_mask,
    output logic              dispatch,
    output logic [LINES-1:0]  ack,
    output logic [ADDR_W-1:0] handler_addr,
    output logic              push_req,
    output logic              push_hi,
    output logic              pc_load,
    output logic              halt_active
);
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    logic             ime, hit, take, busy;
    logic [IDX_W-1:0] win_idx;
    logic [LINES-1:0] live;

    assign live = req_vec & en_mask;

    irqm_pick #(.LINES(LINES), .IDX_W(IDX_W)) u_pick (
        .live (live),
        .hit  (hit),
        .idx  (win_idx)
    );

    irqm_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .busy     (busy),
        .di_stb   (di_stb),
        .ei_stb   (ei_stb),
        .reti_stb (reti_stb),
        .ime      (ime)
    );

    irqm_seq #(
        .LINES(LINES), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE),
        .VEC_STEP(VEC_STEP), .IDX_W(IDX_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .ime          (ime),
        .hit          (hit),
        .idx          (win_idx),
        .halt_stb     (halt_stb),
        .take         (take),
        .busy         (busy),
        .dispatch     (dispatch),
        .ack          (ack),
        .handler_addr (handler_addr),
        .push_req     (push_req),
        .push_hi      (push_hi),
        .pc_load      (pc_load),
        .halt_active  (halt_active)
    );
endmodule

// File: rtl/irqm_chk.sv
module irqm_chk #(
    parameter int LINES  = 5,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [LINES-1:0]  req_vec,
    input logic [LINES-1:0]  en_mask,
    input logic              dispatch,
    input logic [LINES-1:0]  ack,
    input logic [ADDR_W-1:0] handler_addr,
    input logic              push_req,
    input logic              push_hi,
    input logic              pc_load,
    input logic              halt_active
);
    p_ack_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        dispatch |-> ($countones(ack) == 1));

    p_ack_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !dispatch |-> (ack == '0));

    p_single_dispatch_r4: assert property (@(posedge clk) disable iff (rst)
        dispatch |=> !dispatch);

    p_served_pending_r4: assert property (@(posedge clk) disable iff (rst)
        dispatch |-> (($past(req_vec & en_mask) & ack) != '0));

    p_push_hi_r8: assert property (@(posedge clk) disable iff (rst)
        dispatch |-> ##2 (push_req && push_hi));

    p_push_lo_r8: assert property (@(posedge clk) disable iff (rst)
        dispatch |-> ##3 (push_req && !push_hi));

    p_load_r8: assert property (@(posedge clk) disable iff (rst)
        dispatch |-> ##4 (pc_load && !push_req));

    p_addr_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (push_req || pc_load) |-> $stable(handler_addr));

    p_no_halt_entry_r10: assert property (@(posedge clk) disable iff (rst)
        (dispatch || push_req || pc_load) |-> !halt_active);
endmodule

bind irq_master_ctrl irqm_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_vec      (req_vec),
    .en_mask      (en_mask),
    .dispatch     (dispatch),
    .ack          (ack),
    .handler_addr (handler_addr),
    .push_req     (push_req),
    .push_hi      (push_hi),
    .pc_load      (pc_load),
    .halt_active  (halt_active)
);

// File: tb/irq_master_ctrl_tb.sv
module irq_master_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        di_stb = 1'b0, ei_stb = 1'b0, reti_stb = 1'b0, halt_stb = 1'b0;
    logic [4:0]  req_vec = '0;
    logic [4:0]  en_mask = 5'b11111;
    logic [4:0]  raise = '0, drop = '0;
    logic        dispatch, push_req, push_hi, pc_load, halt_active;
    logic [4:0]  ack;
    logic [15:0] handler_addr;

    int n_chk = 0, n_bad = 0, n_disp = 0, ph = 0, base = 0;
    logic [15:0] exp_q[$];
    logic [15:0] cur_addr = '0;

    always #5 clk = ~clk;

    irq_master_ctrl u_dut (
        .clk(clk), .rst(rst), .di_stb(di_stb), .ei_stb(ei_stb),
        .reti_stb(reti_stb), .halt_stb(halt_stb), .req_vec(req_vec),
        .en_mask(en_mask), .dispatch(dispatch), .ack(ack),
        .handler_addr(handler_addr), .push_req(push_req), .push_hi(push_hi),
        .pc_load(pc_load), .halt_active(halt_active)
    );

    // Request flag model: set by raise, cleared by ack or drop.
    always @(posedge clk) begin
        if (rst) req_vec <= '0;
        else     req_vec <= (req_vec & ~ack & ~drop) | raise;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_line(input int i);
        exp_q.push_back(16'(16'h40 + 8 * i));
    endtask

    // Monitor: compares dispatches with the expected queue and walks R8.
    always @(negedge clk) begin
        if (!rst) begin
            if (dispatch) begin
                n_disp++;
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected dispatch", 1, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk("R5 handler_addr", handler_addr, e);
                    chk("R6 ack onehot", ack, 32'(5'b1 << ((e - 16'h40) >> 3)));
                end
                cur_addr = handler_addr;
                ph = 1;
            end else if (ph != 0) begin
                case (ph)
                    1: chk("R8 idle cycle", {push_req, push_hi, pc_load}, 3'b000);
                    2: chk("R8 push high", {push_req, push_hi, pc_load}, 3'b110);
                    3: chk("R8 push low",  {push_req, push_hi, pc_load}, 3'b100);
                    default: chk("R8 load pc", {push_req, push_hi, pc_load}, 3'b001);
                endcase
                chk("R8 addr stable", handler_addr, cur_addr);
                chk("R6 ack quiet", ack, 0);
                ph = (ph == 4) ? 0 : ph + 1;
            end
        end
    end

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1 outputs idle", {dispatch, ack, push_req, push_hi, pc_load, halt_active}, 0);
        base = n_disp;
        raise = 5'b00001; tick(1); raise = '0;
        tick(5);
        chk("R1 flag clear after reset", n_disp, base);
        drop = 5'b00001; tick(1); drop = '0;

        // R5 each line's address
        for (int i = 0; i < 5; i++) begin
            expect_line(i);
            ei_stb = 1'b1; raise = 5'(1 << i); tick(1);
            ei_stb = 1'b0; raise = '0; tick(8);
        end
        chk("R5 all lines served", exp_q.size(), 0);

        // R7 then R3: two lines, entry clears flag, return sets it
        base = n_disp;
        expect_line(2);
        ei_stb = 1'b1; raise = 5'b10100; tick(1);
        ei_stb = 1'b0; raise = '0; tick(10);
        chk("R7 second line held", n_disp, base + 1);
        expect_line(4);
        reti_stb = 1'b1; tick(1); reti_stb = 1'b0; tick(10);
        chk("R3 return re-enables", n_disp, base + 2);

        // R4 masking
        base = n_disp;
        en_mask = 5'b11110;
        expect_line(3);
        ei_stb = 1'b1; raise = 5'b01001; tick(1);
        ei_stb = 1'b0; raise = '0; tick(10);
        ei_stb = 1'b1; tick(1); ei_stb = 1'b0; tick(6);
        chk("R4 masked line not taken", n_disp, base + 1);
        di_stb = 1'b1; drop = 5'b00001; tick(1);
        di_stb = 1'b0; drop = '0; en_mask = 5'b11111; tick(1);

        // R2 disable wins over enable
        base = n_disp;
        di_stb = 1'b1; ei_stb = 1'b1; raise = 5'b00010; tick(1);
        di_stb = 1'b0; ei_stb = 1'b0; raise = '0; tick(6);
        chk("R2 disable wins", n_disp, base);
        expect_line(1);
        ei_stb = 1'b1; tick(1); ei_stb = 1'b0; tick(10);
        chk("R2 enable sets flag", n_disp, base + 1);

        // R9 strobes during entry ignored
        base = n_disp;
        expect_line(0);
        ei_stb = 1'b1; raise = 5'b00011; tick(1);
        ei_stb = 1'b0; raise = '0; tick(1);
        ei_stb = 1'b1; tick(1);           // entry cycle 0
        ei_stb = 1'b0; reti_stb = 1'b1; tick(2);
        reti_stb = 1'b0; tick(8);
        chk("R9 strobes ignored in entry", n_disp, base + 1);
        expect_line(1);
        ei_stb = 1'b1; tick(1); ei_stb = 1'b0; tick(10);

        // R10 / R11 halt with flag clear
        base = n_disp;
        di_stb = 1'b1; tick(1); di_stb = 1'b0;
        halt_stb = 1'b1; tick(1); halt_stb = 1'b0;
        chk("R10 halted", halt_active, 1);
        tick(3);
        chk("R10 stays halted", halt_active, 1);
        raise = 5'b01000; tick(1); raise = '0;
        chk("R10 halted until seen", halt_active, 1);
        tick(1);
        chk("R11 wake without flag", halt_active, 0);
        tick(4);
        chk("R11 no dispatch on wake", n_disp, base);
        drop = 5'b01000; tick(1); drop = '0;

        // R11 halt with flag set
        ei_stb = 1'b1; tick(1); ei_stb = 1'b0;
        halt_stb = 1'b1; tick(1); halt_stb = 1'b0; tick(1);
        chk("R10 halted with flag", halt_active, 1);
        expect_line(2);
        raise = 5'b00100; tick(1); raise = '0; tick(1);
        chk("R11 wake dispatches", dispatch, 1);
        chk("R11 halt ends", halt_active, 0);
        tick(8);
        chk("R11 dispatch counted", n_disp, base + 1);
        chk("R8 queue drained", exp_q.size(), 0);
        summary();
    end
endmodule